// File: doc/BRIEF.md
# Operand Bypass Selector with Register File

This block feeds the two source operands of the operand-read stage in a five-stage in-order pipeline. The stages, in order, are DECODE, ADDRESS, MEMORY, EXECUTE and WRITE BACK, and each instruction moves one stage per cycle. Operands are read while the instruction sits in MEMORY. That is two stages before its result is written back, and one stage ahead of EXECUTE. A result that an older instruction has not yet committed therefore has to be steered backward into MEMORY, either from EXECUTE or from WRITE BACK. With this steering, dependent instructions can be issued on consecutive cycles without a bubble.

The block holds a general purpose register file. WRITE BACK writes it on the clock edge that closes the WRITE BACK cycle. The two-operand instruction form uses its first register as both a source and the destination, so both read indices are compared against both producing stages. Each operand is driven from one of three places: the EXECUTE result, the WRITE BACK result or the register file. A 2-bit source code shows which place was chosen. The ALU, decode, memory access and stall logic sit outside this block.

Top module: `opfwd_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears every register file entry to zero. After reset, with no producer writing, every index reads back 0 with source code 0.
- R2: If ex_wen is 1 and ex_dst equals an operand's read index, that operand equals ex_res in the same cycle and its source code is 1 (EXECUTE).
- R3: If wb_wen is 1 and wb_dst equals an operand's read index, and R2 does not apply to that operand, the operand equals wb_res in the same cycle and its source code is 2 (WRITE BACK).
- R4: If EXECUTE and WRITE BACK both write the register an operand reads, the EXECUTE value wins and the source code is 1.
- R5: A producer with its write-enable low never matches any read index. A WRITE BACK with wb_wen low also leaves the register file unchanged.
- R6: With wb_wen high, the register file entry wb_dst takes wb_res at the rising clock edge. Later reads of that entry with no producer match return it with source code 0.
- R7: The two operands are selected independently. Each may come from a different source, and both may read the same index. The source code never takes the value 3.
- R8: The back-to-back dependent sequence ADD R0,R1; ADD R3,R0; ADD R6,R0; ADD R6,R1 gets the correct operands with no delay. The second instruction takes R0 from EXECUTE, the third takes R0 from WRITE BACK, and the fourth takes R6 from EXECUTE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_idx_a | input | IDXW (4) | First register index of the instruction in MEMORY (source and destination) |
| rd_idx_b | input | IDXW (4) | Second register index of the instruction in MEMORY |
| ex_dst | input | IDXW (4) | Destination index of the instruction in EXECUTE |
| ex_wen | input | 1 | The instruction in EXECUTE writes a register |
| ex_res | input | DW (16) | Result of the instruction in EXECUTE |
| wb_dst | input | IDXW (4) | Destination index of the instruction in WRITE BACK |
| wb_wen | input | 1 | The instruction in WRITE BACK writes a register |
| wb_res | input | DW (16) | Result of the instruction in WRITE BACK |
| opnd_a | output | DW (16) | Value of the first operand |
| opnd_b | output | DW (16) | Value of the second operand |
| sel_a | output | 2 | Source of opnd_a: 0 register file, 1 EXECUTE, 2 WRITE BACK |
| sel_b | output | 2 | Source of opnd_b: 0 register file, 1 EXECUTE, 2 WRITE BACK |

## Verification
Two functions can fall in the same cycle: a register file write from WRITE BACK, and a read of that same register in MEMORY, with EXECUTE sometimes targeting it as well. The bench provokes this by driving matching indices into all three stages at once. It then checks three things: the operand shows the WRITE BACK value before the edge, EXECUTE overrides it when both match, and after the edge the same register reads from the file with source code 0. The dependent ADD sequence is replayed through a cycle-by-cycle stage model kept in the bench, which computes each sum on its own, so that both bypass paths and the file write meet in consecutive cycles.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

   typedef enum logic [1:0] {
      SRC_RF = 2'd0,
      SRC_EX = 2'd1,
      SRC_WB = 2'd2
   } opnd_src_e;

endpackage

// File: rtl/opfwd_regfile.sv
module opfwd_regfile #(
   parameter int DW    = 16,
   parameter int IDXW  = 4,
   parameter int NRD   = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            we,
   input  logic [IDXW-1:0] wa,
   input  logic [DW-1:0]   wd,
   input  logic [IDXW-1:0] ra [NRD],
   output logic [DW-1:0]   rd [NRD]
);
   localparam int DEPTH = 2 ** IDXW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[wa] <= wd;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rd[p] = mem[ra[p]];
   end
endmodule

// File: rtl/opfwd_pick.sv
module opfwd_pick
   import opfwd_pkg::*;
#(
   parameter int DW        = 16,
   parameter int IDXW      = 4,
   parameter bit WB_BYPASS = 1'b1
) (
   input  logic [IDXW-1:0] idx,
   input  logic [IDXW-1:0] ex_dst,
   input  logic            ex_wen,
   input  logic [DW-1:0]   ex_res,
   input  logic [IDXW-1:0] wb_dst,
   input  logic            wb_wen,
   input  logic [DW-1:0]   wb_res,
   input  logic [DW-1:0]   rf_val,
   output logic [DW-1:0]   val,
   output opnd_src_e       src
);
   logic ex_hit;
   logic wb_hit;

   assign ex_hit = ex_wen && (ex_dst == idx);

   if (WB_BYPASS) begin : g_wb_on
      assign wb_hit = wb_wen && (wb_dst == idx);
   end else begin : g_wb_off
      assign wb_hit = 1'b0;
   end

   always_comb begin
      if (ex_hit) begin
         val = ex_res;
         src = SRC_EX;
      end else if (wb_hit) begin
         val = wb_res;
         src = SRC_WB;
      end else begin
         val = rf_val;
         src = SRC_RF;
      end
   end
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
   import opfwd_pkg::*;
#(
   parameter int DW        = 16,
   parameter int NREG      = 16,
   parameter bit WB_BYPASS = 1'b1,
   localparam int IDXW     = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [IDXW-1:0] rd_idx_a,
   input  logic [IDXW-1:0] rd_idx_b,
   input  logic [IDXW-1:0] ex_dst,
   input  logic            ex_wen,
   input  logic [DW-1:0]   ex_res,
   input  logic [IDXW-1:0] wb_dst,
   input  logic            wb_wen,
   input  logic [DW-1:0]   wb_res,
   output logic [DW-1:0]   opnd_a,
   output logic [DW-1:0]   opnd_b,
   output logic [1:0]      sel_a,
   output logic [1:0]      sel_b
);
   localparam int NOPS = 2;

   initial begin
      if (DW < 1) $fatal(1, "opfwd_unit: DW must be positive");
      if (NREG < 2 || (1 << IDXW) != NREG)
         $fatal(1, "opfwd_unit: NREG must be a power of two, at least 2");
   end

   logic [IDXW-1:0] idx_v [NOPS];
   logic [DW-1:0]   rf_v  [NOPS];
   logic [DW-1:0]   val_v [NOPS];
   opnd_src_e       src_v [NOPS];

   assign idx_v[0] = rd_idx_a;
   assign idx_v[1] = rd_idx_b;

   opfwd_regfile #(.DW(DW), .IDXW(IDXW), .NRD(NOPS)) u_rf (
      .clk (clk),
      .rst (rst),
      .we  (wb_wen),
      .wa  (wb_dst),
      .wd  (wb_res),
      .ra  (idx_v),
      .rd  (rf_v)
   );

   for (genvar k = 0; k < NOPS; k++) begin : g_op
      opfwd_pick #(.DW(DW), .IDXW(IDXW), .WB_BYPASS(WB_BYPASS)) u_pick (
         .idx    (idx_v[k]),
         .ex_dst (ex_dst),
         .ex_wen (ex_wen),
         .ex_res (ex_res),
         .wb_dst (wb_dst),
         .wb_wen (wb_wen),
         .wb_res (wb_res),
         .rf_val (rf_v[k]),
         .val    (val_v[k]),
         .src    (src_v[k])
      );
   end

   assign opnd_a = val_v[0];
   assign opnd_b = val_v[1];
   assign sel_a  = src_v[0];
   assign sel_b  = src_v[1];
endmodule

// File: rtl/opfwd_unit_chk.sv
module opfwd_unit_chk #(
   parameter int DW        = 16,
   parameter int IDXW      = 4,
   parameter bit WB_BYPASS = 1'b1
) (
   input logic            clk,
   input logic            rst,
   input logic [IDXW-1:0] rd_idx_a,
   input logic [IDXW-1:0] rd_idx_b,
   input logic [IDXW-1:0] ex_dst,
   input logic            ex_wen,
   input logic [DW-1:0]   ex_res,
   input logic [IDXW-1:0] wb_dst,
   input logic            wb_wen,
   input logic [DW-1:0]   wb_res,
   input logic [DW-1:0]   opnd_a,
   input logic [DW-1:0]   opnd_b,
   input logic [1:0]      sel_a,
   input logic [1:0]      sel_b
);
   // R2, R4: an EXECUTE match wins on either operand
   a_r2_ex_fwd_a: assert property (@(posedge clk) disable iff (rst)
      (ex_wen && ex_dst == rd_idx_a) |-> (opnd_a == ex_res && sel_a == 2'd1));
   a_r2_ex_fwd_b: assert property (@(posedge clk) disable iff (rst)
      (ex_wen && ex_dst == rd_idx_b) |-> (opnd_b == ex_res && sel_b == 2'd1));

   if (WB_BYPASS) begin : g_wb_chk
      // R3: WRITE BACK bypass when EXECUTE does not match
      a_r3_wb_fwd_a: assert property (@(posedge clk) disable iff (rst)
         (wb_wen && wb_dst == rd_idx_a && !(ex_wen && ex_dst == rd_idx_a))
         |-> (opnd_a == wb_res && sel_a == 2'd2));
   end

   // R5: with no producer writing, both operands come from the file
   a_r5_no_wen_rf: assert property (@(posedge clk) disable iff (rst)
      (!ex_wen && !wb_wen) |-> (sel_a == 2'd0 && sel_b == 2'd0));

   // R6: a committed WRITE BACK value is readable from the file next cycle
   a_r6_rf_commit: assert property (@(posedge clk) disable iff (rst)
      ($past(wb_wen && !rst) && !ex_wen && !wb_wen && rd_idx_a == $past(wb_dst))
      |-> (opnd_a == $past(wb_res)));

   // R7: source code is never 3
   a_r7_sel_legal: assert property (@(posedge clk) disable iff (rst)
      (sel_a != 2'd3 && sel_b != 2'd3));
endmodule

bind opfwd_unit opfwd_unit_chk #(.DW(DW), .IDXW(IDXW), .WB_BYPASS(WB_BYPASS)) u_chk (.*);

// File: tb/opfwd_unit_test.sv
`timescale 1ns/1ps
module opfwd_unit_test;
   localparam int DW   = 16;
   localparam int NREG = 16;
   localparam int IW   = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [IW-1:0] rd_idx_a = '0, rd_idx_b = '0, ex_dst = '0, wb_dst = '0;
   logic          ex_wen = 1'b0, wb_wen = 1'b0;
   logic [DW-1:0] ex_res = '0, wb_res = '0;
   logic [DW-1:0] opnd_a, opnd_b;
   logic [1:0]    sel_a, sel_b;

   int checks = 0;
   int fails  = 0;
   logic [DW-1:0] model [NREG];

   always #2.5 clk = ~clk;

   opfwd_unit #(.DW(DW), .NREG(NREG)) uut (
      .clk(clk), .rst(rst), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
      .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_res(ex_res),
      .wb_dst(wb_dst), .wb_wen(wb_wen), .wb_res(wb_res),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .sel_a(sel_a), .sel_b(sel_b)
   );

   task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic drive(input logic [IW-1:0] a, input logic [IW-1:0] b,
                        input logic ew, input logic [IW-1:0] ed, input logic [DW-1:0] er,
                        input logic ww, input logic [IW-1:0] wd, input logic [DW-1:0] wr);
      @(negedge clk);
      rd_idx_a = a; rd_idx_b = b;
      ex_wen = ew; ex_dst = ed; ex_res = er;
      wb_wen = ww; wb_dst = wd; wb_res = wr;
      #0.5;
   endtask

   // bench model of the file update at the coming edge
   task automatic commit();
      if (wb_wen) model[wb_dst] = wb_res;
   endtask

   task automatic t_reset();
      for (int i = 0; i < NREG; i++) model[i] = '0;
      for (int i = 0; i < NREG; i++) begin
         drive(IW'(i), IW'(NREG-1-i), 1'b0, '0, '0, 1'b0, '0, '0);
         chk("R1 opnd_a", opnd_a, '0);
         chk("R1 sel_a", {14'd0, sel_a}, 16'd0);
      end
   endtask

   task automatic t_write();
      for (int i = 0; i < NREG; i++) begin
         drive(IW'(i), IW'(i), 1'b0, '0, '0, 1'b1, IW'(i), 16'h1000 + 16'(i*3));
         chk("R3 same-cycle wb bypass", opnd_a, 16'h1000 + 16'(i*3));
         chk("R3 sel", {14'd0, sel_b}, 16'd2);
         commit();
      end
      for (int i = 0; i < NREG; i++) begin
         drive(IW'(i), IW'(NREG-1-i), 1'b0, '0, '0, 1'b0, '0, '0);
         chk("R6 rf read a", opnd_a, model[i]);
         chk("R6 rf read b", opnd_b, model[NREG-1-i]);
         chk("R6 sel_a", {14'd0, sel_a}, 16'd0);
      end
   endtask

   task automatic t_ex();
      drive(4'd4, 4'd9, 1'b1, 4'd4, 16'hBEEF, 1'b0, '0, '0);
      chk("R2 ex on a", opnd_a, 16'hBEEF);
      chk("R2 sel_a", {14'd0, sel_a}, 16'd1);
      chk("R7 b from rf", opnd_b, model[9]);
      drive(4'd1, 4'd4, 1'b1, 4'd4, 16'h1234, 1'b0, '0, '0);
      chk("R2 ex on b", opnd_b, 16'h1234);
      chk("R2 a untouched", opnd_a, model[1]);
   endtask

   task automatic t_both();
      drive(4'd7, 4'd7, 1'b1, 4'd7, 16'hE0E0, 1'b1, 4'd7, 16'hB0B0);
      chk("R4 ex priority a", opnd_a, 16'hE0E0);
      chk("R4 ex priority b", opnd_b, 16'hE0E0);
      chk("R4 sel_a", {14'd0, sel_a}, 16'd1);
      commit();
      drive(4'd7, 4'd8, 1'b1, 4'd7, 16'h7777, 1'b1, 4'd8, 16'h8888);
      chk("R7 a from ex", opnd_a, 16'h7777);
      chk("R7 b from wb", opnd_b, 16'h8888);
      chk("R7 sel_b", {14'd0, sel_b}, 16'd2);
      commit();
      drive(4'd7, 4'd8, 1'b0, '0, '0, 1'b0, '0, '0);
      chk("R6 wb commit beside ex", opnd_a, 16'hB0B0);
      chk("R6 second commit", opnd_b, 16'h8888);
   endtask

   task automatic t_wen();
      drive(4'd2, 4'd2, 1'b0, 4'd2, 16'hDEAD, 1'b0, 4'd2, 16'hCAFE);
      chk("R5 no match a", opnd_a, model[2]);
      chk("R5 sel_a", {14'd0, sel_a}, 16'd0);
      drive(4'd2, 4'd3, 1'b0, '0, '0, 1'b0, '0, '0);
      chk("R5 file unchanged", opnd_a, model[2]);
   endtask

   task automatic t_seq();
      logic [DW-1:0] r0n, r3n, r6a, r6b;
      // preload R0, R1, R3, R6 through WRITE BACK
      drive(4'd0, 4'd0, 1'b0, '0, '0, 1'b1, 4'd0, 16'd5);  commit();
      drive(4'd0, 4'd0, 1'b0, '0, '0, 1'b1, 4'd1, 16'd7);  commit();
      drive(4'd0, 4'd0, 1'b0, '0, '0, 1'b1, 4'd3, 16'd2);  commit();
      drive(4'd0, 4'd0, 1'b0, '0, '0, 1'b1, 4'd6, 16'd10); commit();
      // cycle A: ADD R0,R1 in MEMORY, no producers
      drive(4'd0, 4'd1, 1'b0, '0, '0, 1'b0, '0, '0);
      chk("R8 i0 src a", opnd_a, 16'd5);
      chk("R8 i0 src b", opnd_b, 16'd7);
      r0n = opnd_a + opnd_b;
      // cycle B: ADD R3,R0 in MEMORY, ADD R0 in EXECUTE
      drive(4'd3, 4'd0, 1'b1, 4'd0, r0n, 1'b0, '0, '0);
      chk("R8 i1 R0 from ex", opnd_b, r0n);
      chk("R8 i1 sel_b", {14'd0, sel_b}, 16'd1);
      r3n = model[3] + r0n;
      // cycle C: ADD R6,R0 in MEMORY, R3 in EXECUTE, R0 in WRITE BACK
      drive(4'd6, 4'd0, 1'b1, 4'd3, r3n, 1'b1, 4'd0, r0n);
      chk("R8 i2 R0 from wb", opnd_b, r0n);
      chk("R8 i2 sel_b", {14'd0, sel_b}, 16'd2);
      chk("R8 i2 R6 from rf", opnd_a, 16'd10);
      r6a = opnd_a + opnd_b;
      commit();
      // cycle D: ADD R6,R1 in MEMORY, R6 in EXECUTE, R3 in WRITE BACK
      drive(4'd6, 4'd1, 1'b1, 4'd6, r6a, 1'b1, 4'd3, r3n);
      chk("R8 i3 R6 from ex", opnd_a, r6a);
      chk("R8 i3 sel_a", {14'd0, sel_a}, 16'd1);
      chk("R8 i3 R1 from rf", opnd_b, 16'd7);
      r6b = opnd_a + opnd_b;
      chk("R8 final sum", r6b, 16'd29);
      commit();
      drive(4'd0, 4'd3, 1'b0, '0, '0, 1'b1, 4'd6, r6a);
      chk("R8 R0 committed", opnd_a, 16'd12);
      chk("R8 R3 committed", opnd_b, 16'd14);
      commit();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_write();
      t_ex();
      t_both();
      t_wen();
      t_seq();
      drive('0, '0, 1'b0, '0, '0, 1'b0, '0, '0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #20000;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule